// File: doc/BRIEF.md
# Three-Channel Piecewise-Linear Transfer Unit

This block applies a programmable transfer curve to each colour channel of a pixel stream. Each of the three channels (red, green, blue) owns a table of 33 breakpoints of 16 bits each. A 10-bit channel value picks one of 32 segments with its upper five bits. Its lower five bits interpolate linearly between the two breakpoints that bound that segment, which gives a 15-bit result. Each channel has its own enable bit. When the bit is clear, the channel skips the table and passes its input through, scaled to the output range.

The tables are written through two ports that share one write strobe: an address port and a data port. An address write sets a load index into one flat entry stream. The stream holds all red breakpoints first, then all green, then all blue. Each data write deposits two consecutive entries of that stream, so a data word can hold the last red entry and the first green entry together. After reset every table holds the identity curve.

Top module: `pwl_channel_lut`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `pix_out` is 0. After reset, all three tables hold the identity curve: entry k equals 512*k, for k = 0 to 32.
- R2: A write with `cfg_sel`=0 (address port) loads the load index from `cfg_wdata[6:0]`. Stream index 0..32 addresses red entries 0..32, index 33..65 addresses green entries 0..32, and index 66..98 addresses blue entries 0..32.
- R3: A write with `cfg_sel`=1 (data port) stores `cfg_wdata[15:0]` at the entry the load index selects and `cfg_wdata[31:16]` at the next entry, then advances the index by two. Index 32 therefore writes red 32 in the low half and green 0 in the high half.
- R4: When a channel is enabled, its input x gives segment k = x[9:5] and fraction f = x[4:0]. The output is e[k] + floor((e[k+1]-e[k])*f/32), limited to the range 0..32767.
- R5: Writing the data port at index 98 stores only blue 32 and drops the upper half. Data writes made while the index is 99 or higher change no entry, and this lasts until the next address write.
- R6: `map_en` bit 0 enables red, bit 1 green and bit 2 blue. A channel whose bit is 0 outputs its 10-bit input shifted left by 4.
- R7: Channel slices are red in bits [9:0]/[14:0], green in [19:10]/[29:15] and blue in [29:20]/[44:30] of `pix_in`/`pix_out`. The result for a pixel, and `out_valid`, appear two clock edges after the edge that samples `pix_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Table port write strobe |
| cfg_sel | input | 1 | 0 = address port, 1 = data port |
| cfg_wdata | input | 32 | Write data: index, or two packed entries |
| map_en | input | 3 | Per-channel mapping enable |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_in | input | 30 | Three 10-bit channel values |
| out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 45 | Three 15-bit channel results |

## Verification
The interpolation bound assertions assume that table contents do not change while a pixel that reads them is in flight. The stimulus never overlaps a table write with a pixel, and it lets each pixel reach the output before the next port write. The bound checks only apply when both breakpoints are at or below 32767 and ordered low to high, so the bench loads both rising and falling curves, plus one that exceeds the range. The index assertions assume that address and data writes never occur in the same cycle, and the single `cfg_sel` input enforces this.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int ENTRY_W = 16;
  localparam int NPTS    = 33;
  localparam int NCH     = 3;
  localparam int TOTAL   = NCH * NPTS;
  localparam int POS_W   = $clog2(NPTS);
  localparam int CH_W    = $clog2(NCH);
  localparam int IDX_W   = $clog2(TOTAL + 2);

  typedef struct packed {
    logic               we;
    logic [CH_W-1:0]    ch;
    logic [POS_W-1:0]   pos;
    logic [ENTRY_W-1:0] data;
  } wr_slot_t;

  // Map a flat stream index onto channel and breakpoint position.
  function automatic wr_slot_t make_slot(logic [IDX_W-1:0] idx, logic we,
                                         logic [ENTRY_W-1:0] d);
    wr_slot_t s;
    s.we   = we && (idx < IDX_W'(TOTAL));
    s.ch   = '0;
    s.pos  = POS_W'(idx);
    s.data = d;
    for (int c = 1; c < NCH; c++) begin
      if (idx >= IDX_W'(c * NPTS)) begin
        s.ch  = CH_W'(c);
        s.pos = POS_W'(idx - IDX_W'(c * NPTS));
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/pwl_loader.sv
module pwl_loader
  import pwl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic                   cfg_sel,
  input  logic [2*ENTRY_W-1:0]   cfg_wdata,
  output wr_slot_t               lo_slot,
  output wr_slot_t               hi_slot
);
  logic [IDX_W-1:0] idx_q;
  logic addr_wr, data_wr, in_range;

  always_comb begin
    addr_wr  = cfg_wr && !cfg_sel;
    data_wr  = cfg_wr && cfg_sel;
    in_range = idx_q < IDX_W'(TOTAL);
    lo_slot  = make_slot(idx_q, data_wr && in_range, cfg_wdata[ENTRY_W-1:0]);
    hi_slot  = make_slot(idx_q + IDX_W'(1), data_wr && in_range,
                         cfg_wdata[2*ENTRY_W-1:ENTRY_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)                       idx_q <= '0;
    else if (addr_wr)              idx_q <= cfg_wdata[IDX_W-1:0];
    else if (data_wr && in_range)  idx_q <= idx_q + IDX_W'(2);
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> idx_q == $past(cfg_wdata[IDX_W-1:0]));  // R2
  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_wr && idx_q < IDX_W'(TOTAL)) |=> idx_q == $past(idx_q) + IDX_W'(2));  // R3
  AST_PAST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
    (idx_q >= IDX_W'(TOTAL - 1)) |-> !hi_slot.we);  // R5
  AST_END_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idx_q >= IDX_W'(TOTAL) && !addr_wr) |=> $stable(idx_q));  // R5
endmodule

// File: rtl/pwl_table.sv
module pwl_table
  import pwl_pkg::*;
#(
  parameter int CH_ID = 0,
  parameter int IN_W  = 10,
  parameter int OUT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_slot_t         lo_slot,
  input  wr_slot_t         hi_slot,
  input  logic             en,
  input  logic [IN_W-1:0]  x_in,
  output logic [OUT_W-1:0] y_out
);
  localparam int SEG_W  = $clog2(NPTS - 1);
  localparam int FRAC_W = IN_W - SEG_W;
  localparam int SHIFT  = OUT_W - 1 - IN_W;
  localparam int STEP   = 1 << (SHIFT + FRAC_W);
  localparam int PROD_W = ENTRY_W + FRAC_W + 2;
  localparam int MAXV   = (1 << OUT_W) - 1;

  logic [ENTRY_W-1:0] mem [NPTS];
  logic [ENTRY_W-1:0] elo_q, ehi_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [IN_W-1:0]    raw_q;
  logic               en_q;
  logic [SEG_W-1:0]   seg;

  logic signed [ENTRY_W:0]  diff;
  logic signed [PROD_W-1:0] prod, sum;
  logic [OUT_W-1:0]         mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPTS; i++) mem[i] <= ENTRY_W'(i * STEP);
    end else begin
      if (lo_slot.we && lo_slot.ch == CH_W'(CH_ID)) mem[lo_slot.pos] <= lo_slot.data;
      if (hi_slot.we && hi_slot.ch == CH_W'(CH_ID)) mem[hi_slot.pos] <= hi_slot.data;
    end
  end

  assign seg = x_in[IN_W-1 -: SEG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      elo_q <= '0; ehi_q <= '0; frac_q <= '0; raw_q <= '0; en_q <= 1'b0;
    end else begin
      elo_q  <= mem[POS_W'(seg)];
      ehi_q  <= mem[POS_W'(seg) + POS_W'(1)];
      frac_q <= x_in[FRAC_W-1:0];
      raw_q  <= x_in;
      en_q   <= en;
    end
  end

  always_comb begin
    diff = $signed({1'b0, ehi_q}) - $signed({1'b0, elo_q});
    prod = diff * $signed({1'b0, frac_q});
    sum  = $signed({{(PROD_W-ENTRY_W){1'b0}}, elo_q}) + (prod >>> FRAC_W);
    if (sum > $signed(PROD_W'(MAXV)))  mapped = OUT_W'(MAXV);
    else if (sum < 0)                  mapped = '0;
    else                               mapped = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       y_out <= '0;
    else if (en_q) y_out <= mapped;
    else           y_out <= {{(OUT_W-IN_W-SHIFT){1'b0}}, raw_q, {SHIFT{1'b0}}};
  end

  AST_INTERP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (en_q && elo_q <= ehi_q && ehi_q <= ENTRY_W'(MAXV))
      |=> (y_out >= OUT_W'($past(elo_q)) && y_out <= OUT_W'($past(ehi_q))));  // R4
  AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (rst)
    (en_q && elo_q > ENTRY_W'(MAXV) && ehi_q > ENTRY_W'(MAXV))
      |=> y_out == OUT_W'(MAXV));  // R4
  AST_BYPASS_SCALE: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> y_out[SHIFT-1:0] == '0);  // R6
endmodule

// File: rtl/pwl_channel_lut.sv
module pwl_channel_lut
  import pwl_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int OUT_W = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr,
  input  logic                  cfg_sel,
  input  logic [2*ENTRY_W-1:0]  cfg_wdata,
  input  logic [NCH-1:0]        map_en,
  input  logic                  pix_valid,
  input  logic [NCH*IN_W-1:0]   pix_in,
  output logic                  out_valid,
  output logic [NCH*OUT_W-1:0]  pix_out
);
  wr_slot_t lo_slot, hi_slot;
  logic     vld_q;

  pwl_loader u_loader (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lo_slot(lo_slot), .hi_slot(hi_slot)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwl_table #(.CH_ID(c), .IN_W(IN_W), .OUT_W(OUT_W)) u_tab (
      .clk(clk), .rst(rst), .lo_slot(lo_slot), .hi_slot(hi_slot),
      .en(map_en[c]), .x_in(pix_in[c*IN_W +: IN_W]),
      .y_out(pix_out[c*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      vld_q     <= pix_valid;
      out_valid <= vld_q;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ##2 out_valid);  // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> ##2 !out_valid);  // R7
endmodule

// File: tb/pwl_channel_lut_test.sv
`timescale 1ns/1ps
module pwl_channel_lut_test;
  localparam int N = 33;
  localparam int TOT = 99;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  map_en = 3'b111;
  logic        pix_valid = 1'b0;
  logic [29:0] pix_in = '0;
  logic        out_valid;
  logic [44:0] pix_out;

  int errors = 0, checks = 0;
  int exp_tab [TOT];
  int midx = 0;

  always #4 clk = ~clk;

  pwl_channel_lut uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .map_en(map_en), .pix_valid(pix_valid),
    .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_addr(input int a);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'(a);
    @(negedge clk);
    cfg_wr = 1'b0;
    midx = a & 127;
  endtask

  task automatic wr_data(input int lo, input int hi);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = {16'(hi), 16'(lo)};
    @(negedge clk);
    cfg_wr = 1'b0;
    if (midx < TOT) begin
      exp_tab[midx] = lo & 16'hffff;
      if (midx + 1 < TOT) exp_tab[midx + 1] = hi & 16'hffff;
      midx += 2;
    end
  endtask

  function automatic int model(input int c, input int x, input bit en);
    int k, f, lo, hi, r;
    if (!en) return x * 16;
    k = x >> 5; f = x & 31;
    lo = exp_tab[c*N + k]; hi = exp_tab[c*N + k + 1];
    r = lo + (((hi - lo) * f) >>> 5);
    if (r > 32767) r = 32767;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic run_pix(input int xr, input int xg, input int xb, input string tag);
    int xs [3];
    xs[0] = xr; xs[1] = xg; xs[2] = xb;
    @(negedge clk);
    pix_valid = 1'b1;
    pix_in = {10'(xb), 10'(xg), 10'(xr)};
    @(negedge clk);
    pix_valid = 1'b0;
    check(int'(out_valid), 0, "R7 early valid");
    @(negedge clk);
    check(int'(out_valid), 1, "R7 valid");
    for (int c = 0; c < 3; c++)
      check(int'(pix_out[c*15 +: 15]), model(c, xs[c], map_en[c]), tag);
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 1024; v++)
      run_pix(v, 1023 - v, (v * 37) & 1023, tag);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOT; i++) exp_tab[i] = (i % N) * 512;
    repeat (3) @(negedge clk);
    check(int'(out_valid), 0, "R1 reset valid");
    check(int'(pix_out), 0, "R1 reset data");
    @(negedge clk);
    rst = 1'b0;
    check(int'(out_valid), 0, "R1 post-reset valid");
    check(int'(pix_out), 0, "R1 post-reset data");

    // R1: identity tables after reset, all channels mapped
    map_en = 3'b111;
    sweep("R1 identity");
    // R6: full bypass
    map_en = 3'b000;
    sweep("R6 bypass");

    // R2 R3: stream load from index 0; word 17 straddles red 32 / green 0
    wr_addr(0);
    for (int w = 0; w < 50; w++) begin
      int a, b, lo, hi;
      a = 2 * w; b = 2 * w + 1;
      lo = (a < N) ? a * 1000 : (a < 2*N) ? 32767 - (a - N) * 1000 : (a - 2*N) * 1100;
      hi = (b < N) ? b * 1000 : (b < 2*N) ? 32767 - (b - N) * 1000 : (b - 2*N) * 1100;
      if (b >= TOT) hi = 16'h5a5a;
      wr_data(lo, hi);
    end
    map_en = 3'b111;
    sweep("R4 custom curves");
    map_en = 3'b010;
    sweep("R6 green only");
    map_en = 3'b101;
    sweep("R6 red blue");

    // R5: writes past the end change nothing; index 98 keeps only the low half
    wr_data(16'hffff, 16'hffff);
    wr_data(16'h1111, 16'h2222);
    wr_addr(98);
    wr_data(16'h1234, 16'haaaa);
    wr_data(16'h7777, 16'h7777);
    wr_addr(99);
    wr_data(16'h0001, 16'h0002);
    wr_addr(127);
    wr_data(16'h0003, 16'h0004);
    map_en = 3'b111;
    sweep("R5 end of stream");

    // R2 R3: odd index start and explicit straddle word
    wr_addr(33);
    wr_data(16'h7000, 16'h0100);
    wr_addr(32);
    wr_data(16'h3333, 16'h2222);
    wr_addr(65);
    wr_data(16'h0040, 16'h6000);
    sweep("R3 straddle reload");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule